// File: doc/BRIEF.md
# Masked Event Interrupt Aggregator

This block keeps the pending-event state of an Ethernet DMA controller and turns it into three level interrupt lines: transmit, receive and error. Data-path logic raises events with one-cycle set pulses, one bit per event. Software acknowledges events by writing ones to the event register and enables or silences them through a mask register that it overwrites whole.

An event contributes to an interrupt only while its mask bit is also set. The set of enabled, pending events is split into three groups. Each group is chosen by its own parameter mask, and each group drives one registered output. The bus decode that produces the two write strobes lies outside this block. So do the producers of the set pulses. The write strobes are single-cycle commands with no back-pressure: the block accepts a write in every cycle, so no ready signal exists, and every port is a plain control or status pin.

Top module: `evt_irq_aggregator`

## Requirements
- R1: While reset is asserted, and right after it, the event register and the mask register read zero and all three interrupt outputs are low.
- R2: A 1 on any bit of the hardware set input sets that event bit at the next clock edge. The bit then stays set until software clears it; masking it does not clear it.
- R3: A software event write clears, at the next edge, every event bit whose write-data bit is 1. Event bits whose write-data bit is 0 keep their value.
- R4: A software mask write replaces the entire mask register with the write data at the next edge.
- R5: When a hardware set and a software clear hit the same event bit in the same cycle, the bit ends up set.
- R6: The transmit interrupt is high exactly when (event AND mask AND TX group) is non-zero. It lags the register values by one clock. The default TX group is bits 15:8.
- R7: The receive interrupt follows the same rule with the RX group, default bits 23:16, and the same one-clock lag.
- R8: The error interrupt follows the same rule with the ERR group, default bits 31:24 and 7:0, and the same one-clock lag.
- R9: An event that is pending while masked raises its group's interrupt once its mask bit is later set. No new set pulse is needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_set | input | 32 | Per-bit event set pulses from the data path |
| sw_wr_evt | input | 1 | Software write strobe for the event register (write-one-to-clear) |
| sw_wr_mask | input | 1 | Software write strobe for the mask register |
| sw_wdata | input | 32 | Software write data |
| event_q | output | 32 | Current event register |
| mask_q | output | 32 | Current mask register |
| irq_tx | output | 1 | Transmit interrupt level |
| irq_rx | output | 1 | Receive interrupt level |
| irq_err | output | 1 | Error interrupt level |

## Verification
The bench targets a set pulse that meets a write-one-to-clear on the same bit. A design that lets the clear win loses that event, so the event register reads 0 where 1 is expected. A clear written with all-zero data must leave the register alone; a design that treats the write as a plain overwrite wipes the pending bits instead. Mask writes must replace the old value; a design that ORs them in keeps a stale group's interrupt high. The bench also samples the interrupts in the cycle after a register change and again one cycle later, to catch an output that is combinational or delayed twice. It also checks that an event held under a mask fires once the mask opens.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int unsigned NUM_GROUPS = 3;

  typedef enum logic [1:0] {
    GRP_TX  = 2'd0,
    GRP_RX  = 2'd1,
    GRP_ERR = 2'd2
  } grp_e;
endpackage

// File: rtl/evt_irq_event_reg.sv
module evt_irq_event_reg #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set_i,
  input  logic             clr_en_i,
  input  logic [WIDTH-1:0] clr_bits_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] clr_vec;
  logic [WIDTH-1:0] nxt;

  always_comb begin
    clr_vec = clr_en_i ? clr_bits_i : '0;
    // set after clear: a simultaneous set survives
    nxt     = (q_o & ~clr_vec) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= nxt;
  end

  AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((q_o & $past(set_i)) == $past(set_i)));            // R5
  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en_i |=> ((q_o & $past(clr_bits_i & ~set_i)) == '0));       // R3
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_en_i && set_i == '0) |=> $stable(q_o));                   // R2
endmodule

// File: rtl/evt_irq_mask_reg.sv
module evt_irq_mask_reg #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_o <= '0;
    else if (wr_i) q_o <= wdata_i;
  end

  AST_MASK_REPLACED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (q_o == $past(wdata_i)));                              // R4
  AST_MASK_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(q_o));                                        // R4
endmodule

// File: rtl/evt_irq_group_reduce.sv
module evt_irq_group_reduce #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned GROUPS = 3,
  parameter logic [GROUPS-1:0][WIDTH-1:0] GRP_MASKS = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WIDTH-1:0]  active_i,
  output logic [GROUPS-1:0] irq_o
);
  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    logic hit;
    assign hit = |(active_i & GRP_MASKS[g]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_o[g] <= 1'b0;
      else        irq_o[g] <= hit;
    end

    AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o[g] |-> $past(active_i != '0));                          // R6 R7 R8
  end
endmodule

// File: rtl/evt_irq_aggregator.sv
module evt_irq_aggregator #(
  parameter int unsigned WIDTH   = 32,
  parameter logic [WIDTH-1:0] TX_GROUP  = 32'h0000_FF00,
  parameter logic [WIDTH-1:0] RX_GROUP  = 32'h00FF_0000,
  parameter logic [WIDTH-1:0] ERR_GROUP = 32'hFF00_00FF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] hw_set,
  input  logic             sw_wr_evt,
  input  logic             sw_wr_mask,
  input  logic [WIDTH-1:0] sw_wdata,
  output logic [WIDTH-1:0] event_q,
  output logic [WIDTH-1:0] mask_q,
  output logic             irq_tx,
  output logic             irq_rx,
  output logic             irq_err
);
  import evt_irq_pkg::*;

  localparam logic [NUM_GROUPS-1:0][WIDTH-1:0] GRP_MASKS = {ERR_GROUP, RX_GROUP, TX_GROUP};

  logic [WIDTH-1:0]      active;
  logic [NUM_GROUPS-1:0] irq_vec;

  evt_irq_event_reg #(.WIDTH(WIDTH)) u_evt (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (hw_set),
    .clr_en_i   (sw_wr_evt),
    .clr_bits_i (sw_wdata),
    .q_o        (event_q)
  );

  evt_irq_mask_reg #(.WIDTH(WIDTH)) u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (sw_wr_mask),
    .wdata_i (sw_wdata),
    .q_o     (mask_q)
  );

  assign active = event_q & mask_q;

  evt_irq_group_reduce #(
    .WIDTH     (WIDTH),
    .GROUPS    (NUM_GROUPS),
    .GRP_MASKS (GRP_MASKS)
  ) u_reduce (
    .clk      (clk),
    .rst_n    (rst_n),
    .active_i (active),
    .irq_o    (irq_vec)
  );

  assign irq_tx  = irq_vec[GRP_TX];
  assign irq_rx  = irq_vec[GRP_RX];
  assign irq_err = irq_vec[GRP_ERR];

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past((event_q & mask_q) == '0) |-> !(irq_tx || irq_rx || irq_err)); // R9
  AST_TX_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    $past((event_q & mask_q & TX_GROUP) != '0) |-> irq_tx);         // R6
  AST_RX_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    $past((event_q & mask_q & RX_GROUP) != '0) |-> irq_rx);         // R7
  AST_ERR_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    $past((event_q & mask_q & ERR_GROUP) != '0) |-> irq_err);       // R8
endmodule

// File: tb/test_evt_irq_aggregator.sv
module test_evt_irq_aggregator;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] hw_set = '0;
  logic        sw_wr_evt = 1'b0;
  logic        sw_wr_mask = 1'b0;
  logic [31:0] sw_wdata = '0;
  logic [31:0] event_q, mask_q;
  logic        irq_tx, irq_rx, irq_err;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  evt_irq_aggregator i_evt_irq_aggregator (
    .clk(clk), .rst_n(rst_n), .hw_set(hw_set), .sw_wr_evt(sw_wr_evt),
    .sw_wr_mask(sw_wr_mask), .sw_wdata(sw_wdata), .event_q(event_q),
    .mask_q(mask_q), .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_err(irq_err)
  );

  typedef struct packed {
    logic [31:0] hw;
    logic        we;
    logic        wm;
    logic [31:0] wd;
    logic [31:0] ev;
    logic [31:0] mk;
    logic [2:0]  irq; // {tx, rx, err}
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t TBL [NV] = '{
    '{32'h0000_0100, 1'b0, 1'b0, 32'h0,          32'h0000_0100, 32'h0,          3'b000, 4'd2},
    '{32'h0,         1'b0, 1'b1, 32'h0000_FF00, 32'h0000_0100, 32'h0000_FF00, 3'b100, 4'd9},
    '{32'h0001_0000, 1'b0, 1'b0, 32'h0,          32'h0001_0100, 32'h0000_FF00, 3'b100, 4'd2},
    '{32'h0,         1'b0, 1'b1, 32'h00FF_0000, 32'h0001_0100, 32'h00FF_0000, 3'b010, 4'd4},
    '{32'h8000_0000, 1'b0, 1'b1, 32'hFFFF_FFFF, 32'h8001_0100, 32'hFFFF_FFFF, 3'b111, 4'd8},
    '{32'h0,         1'b1, 1'b0, 32'h0001_0000, 32'h8000_0100, 32'hFFFF_FFFF, 3'b101, 4'd3},
    '{32'h0000_0100, 1'b1, 1'b0, 32'h0000_0100, 32'h8000_0100, 32'hFFFF_FFFF, 3'b101, 4'd5},
    '{32'h0,         1'b1, 1'b0, 32'h8000_0100, 32'h0,          32'hFFFF_FFFF, 3'b000, 4'd3},
    '{32'h0000_0001, 1'b0, 1'b0, 32'h0,          32'h0000_0001, 32'hFFFF_FFFF, 3'b001, 4'd8},
    '{32'h0,         1'b1, 1'b0, 32'h0,          32'h0000_0001, 32'hFFFF_FFFF, 3'b001, 4'd3}
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [2:0] irqs();
    return {irq_tx, irq_rx, irq_err};
  endfunction

  task automatic idle();
    hw_set = '0; sw_wr_evt = 1'b0; sw_wr_mask = 1'b0; sw_wdata = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<=5000", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "event during reset", event_q, 32'h0);
    chk("R1", "irqs during reset", {29'h0, irqs()}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "mask after reset", mask_q, 32'h0);
    chk("R1", "irqs after reset", {29'h0, irqs()}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      string r;
      r = $sformatf("R%0d", TBL[i].req);
      hw_set = TBL[i].hw; sw_wr_evt = TBL[i].we; sw_wr_mask = TBL[i].wm; sw_wdata = TBL[i].wd;
      @(negedge clk);
      idle();
      chk(r, "event", event_q, TBL[i].ev);
      chk(r, "mask", mask_q, TBL[i].mk);
      @(negedge clk);
      chk(r, "irqs", {29'h0, irqs()}, {29'h0, TBL[i].irq});
    end

    // R6: registered lag, clean state, mask TX open
    sw_wr_evt = 1'b1; sw_wdata = 32'hFFFF_FFFF;
    @(negedge clk); idle();
    @(negedge clk);
    chk("R6", "tx low before set", {31'h0, irq_tx}, 32'h0);
    hw_set = 32'h0000_0200;
    @(negedge clk); idle();
    chk("R6", "tx not yet high one cycle after hw_set edge", {31'h0, irq_tx}, 32'h0);
    @(negedge clk);
    chk("R6", "tx high after lag", {31'h0, irq_tx}, 32'h1);
    // R7: rx event also held
    hw_set = 32'h0040_0000;
    @(negedge clk); idle(); @(negedge clk);
    chk("R7", "rx high", {31'h0, irq_rx}, 32'h1);
    chk("R8", "err stays low", {31'h0, irq_err}, 32'h0);
    // R9: masking keeps events, unmask restores irq
    sw_wr_mask = 1'b1; sw_wdata = 32'h0;
    @(negedge clk); idle(); @(negedge clk);
    chk("R9", "all irqs low when masked", {29'h0, irqs()}, 32'h0);
    chk("R2", "events kept under mask", event_q, 32'h0040_0200);
    sw_wr_mask = 1'b1; sw_wdata = 32'h00FF_0000;
    @(negedge clk); idle(); @(negedge clk);
    chk("R9", "rx returns on unmask", {29'h0, irqs()}, 32'h2);

    // R1: reset mid-operation
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", "event after mid reset", event_q, 32'h0);
    chk("R1", "mask after mid reset", mask_q, 32'h0);
    chk("R1", "irqs after mid reset", {29'h0, irqs()}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule